// File: doc/BRIEF.md
# Trace Capture Pointer Controller

This block owns a single-ported memory of trace entries and the two pointers that walk it. Traced events arrive as a stream of entries and are stored at the write pointer. A host pulls them out one at a time at the read pointer. Because the memory has one port, a trace write and a host read never share a cycle. The trace side always wins, and the host read waits for the next free cycle.

A trace session starts when `enable` rises, which returns both pointers to slot 0. In wrapping mode, capture runs around the buffer without end. In fill-once mode, capture stops for good after the buffer has taken one full load.

When the buffer holds a full load in wrapping mode, new entries are discarded until a read frees a slot. The first entry stored after such a loss is tagged as following a gap. Every returned word carries a 2-bit status in its top bits. A read from an empty buffer returns a not-valid word and leaves the read pointer where it was.

An interrupt pulse marks each time the buffer occupancy climbs to a chosen level: half, three quarters or full. Occupancy is the write pointer minus the read pointer.

The trace input has no ready signal. It is never back-pressured, and an entry that cannot be stored is dropped. The host read request follows valid/ready rules. A request is taken on a cycle where `rd_valid` and `rd_ready` are both high, and the host keeps `rd_valid` high until then. `rd_ready` is low in any cycle that stores a trace entry and in the cycle a session starts. The response shows on `rsp_valid`/`rsp_data` exactly one cycle after acceptance, with no back-pressure on the response.

Top module: `trace_ptr_ctrl`

## Requirements
- R1: On the cycle `enable` is high after being low, both pointers return to slot 0, the gap tag clears, no entry is stored and no read is accepted; a read that follows before any store returns a not-valid word.
- R2: In wrapping mode, stored entries are returned in the order they were stored, across any number of passes around the buffer, with status 2'b10 in bits [ENTRY_W+1:ENTRY_W] and the entry in the low ENTRY_W bits.
- R3: In fill-once mode, once DEPTH entries have been stored since the session start, every further trace entry is discarded, even after reads empty the buffer.
- R4: In wrapping mode, a trace entry offered while occupancy equals DEPTH is discarded; storing resumes on the first offer after a read has freed a slot.
- R5: The first entry stored after one or more entries were discarded in wrapping mode returns status 2'b11; later entries return 2'b10.
- R6: A read accepted while occupancy is zero returns an all-zero word (status 2'b00) and does not advance the read pointer.
- R7: `rd_ready` is low exactly in cycles that store a trace entry or start a session; each accepted read gives `rsp_valid` high for one cycle, one cycle later.
- R8: `irq` is high for one cycle, in the cycle after a store that makes occupancy equal the level chosen by `thr_sel`. The levels are: 1 = DEPTH/2, 2 = 3*DEPTH/4, 3 = DEPTH, and 0 = never.
- R9: While `enable` is low, trace entries are ignored and the buffer contents stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable; a rising level starts a session |
| wrap_mode | input | 1 | 1 = wrapping capture, 0 = fill-once capture |
| thr_sel | input | 2 | Interrupt level select (0 off, 1 half, 2 three quarters, 3 full) |
| trc_valid | input | 1 | Trace entry offered this cycle |
| trc_data | input | ENTRY_W | Trace entry payload |
| rd_valid | input | 1 | Host read request |
| rd_ready | output | 1 | Memory port free for a host read this cycle |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | ENTRY_W+2 | Status in the top 2 bits, entry below |
| irq | output | 1 | One-cycle occupancy threshold pulse |

## Verification
Directed sequences cover several situations:
- An empty read straight after a session start, which separates the underflow word from a stale entry.
- A fill past capacity followed by one read and one store, which shows a dropped entry, the gap tag, and the tag's single use.
- A fill-once session pushed past capacity and then drained, which separates a permanent stop from a full-buffer stall.
- Offers made with capture disabled.

Seeded random traffic then mixes stores, held read requests, threshold choices and session restarts. This exposes ordering faults across pointer wrap, arbitration slips, and interrupt pulses at the wrong occupancy or on repeated crossings.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    THR_OFF  = 2'd0,
    THR_HALF = 2'd1,
    THR_3Q   = 2'd2,
    THR_FULL = 2'd3
  } thr_e;

  localparam logic [1:0] ST_NONE = 2'b00;
  localparam logic [1:0] ST_OK   = 2'b10;
  localparam logic [1:0] ST_GAP  = 2'b11;

  // Occupancy at which the threshold pulse fires; 0 never matches a post-store count.
  function automatic int unsigned thr_level(input thr_e sel, input int unsigned depth);
    case (sel)
      THR_HALF: return depth / 2;
      THR_3Q:   return depth - depth / 4;
      THR_FULL: return depth;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/tpc_ptrs.sv
module tpc_ptrs #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wrap_mode,
  input  logic          trc_valid,
  input  logic          rd_fire,
  output logic          start,
  output logic          wr_fire,
  output logic          wr_gap,
  output logic [PW-1:0] wr_addr,
  output logic [PW-1:0] rd_addr,
  output logic          rd_empty,
  output logic [PW:0]   occ
);

  localparam logic [PW:0] FULL_OCC = (PW+1)'(DEPTH);

  logic          en_q;
  logic [PW:0]   wp, rp;
  logic          miss;
  logic          room, drop, offer;

  assign start    = enable & ~en_q;
  assign occ      = wp - rp;
  assign rd_empty = (occ == '0);
  // fill-once: the extra pointer bit marks one full load since start
  assign room     = wrap_mode ? (occ != FULL_OCC) : ~wp[PW];
  assign offer    = trc_valid & enable & ~start;
  assign wr_fire  = offer & room;
  assign drop     = offer & ~room & wrap_mode;
  assign wr_gap   = miss;
  assign wr_addr  = wp[PW-1:0];
  assign rd_addr  = rp[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      wp   <= '0;
      rp   <= '0;
      miss <= 1'b0;
    end else begin
      en_q <= enable;
      if (start) begin
        wp   <= '0;
        rp   <= '0;
        miss <= 1'b0;
      end else begin
        if (wr_fire) begin
          wp   <= wp + 1'b1;
          miss <= 1'b0;
        end else if (drop) begin
          miss <= 1'b1;
        end
        if (rd_fire && !rd_empty) rp <= rp + 1'b1;
      end
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_OCC); // R4

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (wp == '0 && rp == '0 && !miss)); // R1

  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_empty) |=> (rp == $past(rp))); // R6

  AST_FILL_ONCE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_mode && wp[PW] && !start) |=> $stable(wp)); // R3

endmodule

// File: rtl/tpc_store.sv
module tpc_store #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 62,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic [PW-1:0]        wr_addr,
  input  logic                 wr_gap,
  input  logic [ENTRY_W-1:0]   wr_data,
  input  logic                 rd_fire,
  input  logic [PW-1:0]        rd_addr,
  input  logic                 rd_empty,
  output logic                 rsp_valid,
  output logic [ENTRY_W+1:0]   rsp_data
);
  import tpc_pkg::*;

  logic [ENTRY_W:0] mem [DEPTH];
  logic [ENTRY_W:0] slot;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= {wr_gap, wr_data};
  end

  assign slot = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        if (rd_empty) rsp_data <= {ST_NONE, {ENTRY_W{1'b0}}};
        else          rsp_data <= {(slot[ENTRY_W] ? ST_GAP : ST_OK), slot[ENTRY_W-1:0]};
      end
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid); // R7

  AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_empty) |=> (rsp_data[ENTRY_W+1:ENTRY_W] == ST_NONE)); // R6

  AST_PORT_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && rd_fire)); // R7

endmodule

// File: rtl/tpc_thresh.sv
module tpc_thresh #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic [PW:0] occ,
  input  logic [1:0]  thr_sel,
  output logic        irq
);
  import tpc_pkg::*;

  logic [PW:0] level;
  logic [PW:0] next_occ;

  assign level    = (PW+1)'(thr_level(thr_e'(thr_sel), DEPTH));
  assign next_occ = occ + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wr_fire && (next_occ == level);
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8

endmodule

// File: rtl/trace_ptr_ctrl.sv
module trace_ptr_ctrl #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 62
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               wrap_mode,
  input  logic [1:0]         thr_sel,
  input  logic               trc_valid,
  input  logic [ENTRY_W-1:0] trc_data,
  input  logic               rd_valid,
  output logic               rd_ready,
  output logic               rsp_valid,
  output logic [ENTRY_W+1:0] rsp_data,
  output logic               irq
);

  localparam int PW = $clog2(DEPTH);

  logic          start, wr_fire, wr_gap, rd_fire, rd_empty;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [PW:0]   occ;

  // trace store owns the port; a host read only gets a free cycle
  assign rd_ready = ~wr_fire & ~start;
  assign rd_fire  = rd_valid & rd_ready;

  tpc_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wrap_mode(wrap_mode),
    .trc_valid(trc_valid), .rd_fire(rd_fire), .start(start),
    .wr_fire(wr_fire), .wr_gap(wr_gap), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_empty(rd_empty), .occ(occ)
  );

  tpc_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_gap(wr_gap), .wr_data(trc_data), .rd_fire(rd_fire),
    .rd_addr(rd_addr), .rd_empty(rd_empty),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  tpc_thresh #(.DEPTH(DEPTH)) u_thresh (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .occ(occ),
    .thr_sel(thr_sel), .irq(irq)
  );

  AST_START_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !$past(enable)) |-> !rd_ready); // R1

endmodule

// File: tb/sim_trace_ptr_ctrl.sv
`timescale 1ns/1ps
module sim_trace_ptr_ctrl;

  localparam int DEPTH   = 16;
  localparam int ENTRY_W = 62;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic               wrap_mode = 1'b1;
  logic [1:0]         thr_sel = 2'd0;
  logic               trc_valid = 1'b0;
  logic [ENTRY_W-1:0] trc_data = '0;
  logic               rd_valid = 1'b0;
  logic               rd_ready;
  logic               rsp_valid;
  logic [ENTRY_W+1:0] rsp_data;
  logic               irq;

  always #2.5 clk = ~clk;

  trace_ptr_ctrl #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wrap_mode(wrap_mode),
    .thr_sel(thr_sel), .trc_valid(trc_valid), .trc_data(trc_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  // bench model
  logic [ENTRY_W:0]   q[$];
  int                 wtot = 0;
  bit                 miss = 0;
  bit                 m_en = 0;
  bit                 exp_rv = 0;
  bit                 exp_irq = 0;
  logic [ENTRY_W+1:0] exp_rd = '0;

  function automatic int level_of(input logic [1:0] s);
    case (s)
      2'd1: return DEPTH / 2;
      2'd2: return DEPTH - DEPTH / 4;
      2'd3: return DEPTH;
      default: return -1;
    endcase
  endfunction

  function automatic logic [ENTRY_W+1:0] word_of(input bit empty, input logic [ENTRY_W:0] e);
    if (empty) return '0;
    return {1'b1, e};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit wr, input logic [1:0] th, input bit tv, input bit rv);
    bit start, room, wfire, drop, rdy, rfire;
    logic [ENTRY_W-1:0] d;
    logic [ENTRY_W:0] e;
    @(negedge clk);
    chk(rsp_valid == exp_rv, "R7 rsp_valid", 64'(rsp_valid), 64'(exp_rv));
    if (exp_rv) chk(rsp_data == exp_rd, tag, 64'(rsp_data), 64'(exp_rd));
    chk(irq == exp_irq, "R8 irq", 64'(irq), 64'(exp_irq));
    d = {$urandom, $urandom};
    enable = en; wrap_mode = wr; thr_sel = th; trc_valid = tv; trc_data = d; rd_valid = rv;
    #1;
    start = en && !m_en;
    room  = wr ? (q.size() < DEPTH) : (wtot < DEPTH);
    wfire = tv && en && !start && room;
    drop  = tv && en && !start && !room && wr;
    rdy   = !start && !wfire;
    rfire = rv && rdy;
    chk(rd_ready == rdy, "R7 rd_ready", 64'(rd_ready), 64'(rdy));
    exp_irq = wfire && ((q.size() + 1) == level_of(th));
    if (start) begin q.delete(); wtot = 0; miss = 0; end
    if (wfire) begin q.push_back({miss, d}); wtot++; miss = 0; end
    else if (drop) miss = 1;
    exp_rv = rfire;
    if (rfire) begin
      if (q.size() == 0) exp_rd = word_of(1, '0);
      else begin e = q.pop_front(); exp_rd = word_of(0, e); end
    end
    m_en = en;
  endtask

  task automatic writes(input int n, input bit wr, input logic [1:0] th);
    for (int i = 0; i < n; i++) step(1, wr, th, 1, 0);
  endtask

  task automatic reads(input int n, input bit wr, input logic [1:0] th);
    for (int i = 0; i < n; i++) step(1, wr, th, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(rsp_valid == 0, "R1 reset rsp_valid", 64'(rsp_valid), 0);
    chk(irq == 0, "R1 reset irq", 64'(irq), 0);
    chk(rd_ready == 1, "R1 reset rd_ready", 64'(rd_ready), 1);
    // R1 start then empty read; R6 underflow holds pointer
    tag = "R1 start/empty";
    step(1, 1, 2'd1, 0, 1);
    reads(2, 1, 2'd1);
    tag = "R6 underflow";
    reads(2, 1, 2'd1);
    writes(1, 1, 2'd1);
    reads(2, 1, 2'd1);
    // R2 order in wrapping mode
    tag = "R2 order";
    writes(5, 1, 2'd1);
    reads(5, 1, 2'd1);
    // R4/R5/R8 fill past capacity
    tag = "R4 full drop";
    writes(DEPTH + 3, 1, 2'd3);
    reads(1, 1, 2'd3);
    tag = "R5 gap tag";
    writes(2, 1, 2'd3);
    reads(DEPTH + 1, 1, 2'd3);
    // R8 three-quarter level
    tag = "R8 level";
    writes(DEPTH, 1, 2'd2);
    reads(DEPTH, 1, 2'd0);
    // R3 fill-once
    step(0, 0, 2'd1, 0, 0);
    tag = "R3 fill-once";
    step(1, 0, 2'd1, 0, 0);
    writes(DEPTH + 3, 0, 2'd1);
    reads(4, 0, 2'd1);
    writes(3, 0, 2'd1);
    reads(DEPTH, 0, 2'd1);
    // R9 disabled capture
    tag = "R9 disabled";
    for (int i = 0; i < 4; i++) step(0, 0, 2'd1, 1, 0);
    for (int i = 0; i < 2; i++) step(0, 0, 2'd1, 0, 1);
    // random mix with held read requests
    tag = "R2 random";
    begin
      bit wr = 1;
      bit rv = 0;
      logic [1:0] th = 2'd1;
      for (int c = 0; c < 4000; c++) begin
        bit en = 1;
        if (c % 700 == 699) begin en = 0; wr = ($urandom % 4) != 0; th = 2'($urandom); end
        if (!rv) rv = ($urandom % 100) < 40;
        step(en, wr, th, ($urandom % 100) < 50, rv);
        if (rv && rd_ready) rv = 0;
      end
    end
    step(1, 1, 2'd0, 0, 0);
    step(1, 1, 2'd0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule